// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block drives the two supply-related outputs of an LCD controller: the controller enable line and the panel power line. A host issues a one-cycle command carrying a wanted enable bit and a wanted power bit. The block never moves both outputs at once. When going up, it raises enable, waits a settling interval so the panel contrast voltage can stabilise, and only then raises power. When going down, it removes power first, waits the same interval, and then drops enable.

The settling interval is a count of reference-clock cycles set by a parameter. The default corresponds to 20 ms at a 250 MHz clock, and a simulation can use a short value. A command that arrives while a wait is in progress is kept in a single slot, and a later one overwrites it. The held command is applied after the current sequence has completed. The block reports its current phase and a busy flag that is high during every wait.

Top module: `lcd_power_seq`

## Requirements
- R1: After reset, panel_en_o=0, panel_pwr_o=0, busy_o=0 and phase_o=0 (OFF).
- R2: A command with enable=1 and power=1 taken while the panel is unpowered raises panel_en_o on the clock edge that takes it. On that same edge panel_pwr_o stays 0, busy_o goes high and phase_o goes to 3 (UP_WAIT).
- R3: panel_pwr_o rises exactly SETTLE_CYCLES cycles after the power-up wait starts. On that edge busy_o falls and phase_o becomes 2 (ON).
- R4: A shutdown command (enable=0) taken while powered clears panel_pwr_o on the edge that takes it and sets phase_o to 5 (SHUT_WAIT). panel_en_o stays high for SETTLE_CYCLES cycles and then clears, with phase_o going to 0.
- R5: A shutdown command taken while enabled but unpowered (phase 1) leaves panel_pwr_o at 0. It still holds panel_en_o high through a full SETTLE_CYCLES wait in phase 5 before clearing it.
- R6: A command with enable=1 and power=0 taken while fully off raises panel_en_o at once. There is no wait: busy_o stays 0 and phase_o becomes 1 (ENABLED).
- R7: A command with enable=1 and power=0 taken while powered clears panel_pwr_o at once and enters phase 4 (DROP_WAIT). After SETTLE_CYCLES cycles it settles in phase 1 with panel_en_o still high.
- R8: A command that arrives during a wait does not change the outputs until the wait ends. The newest such command is applied on the cycle after the sequence reaches its stable phase.
- R9: panel_pwr_o is never high while panel_en_o is low.
- R10: busy_o is high exactly when phase_o is 3, 4 or 5.
- R11: A command that asks for the state already in place (including shutdown while fully off) changes nothing and does not raise busy_o.
- R12: A command with enable=0 and power=1 is treated as a shutdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle strobe carrying a new command |
| req_enable_i | input | 1 | Wanted state of the controller enable |
| req_power_i | input | 1 | Wanted state of panel power |
| panel_en_o | output | 1 | Controller enable output |
| panel_pwr_o | output | 1 | Panel power output |
| busy_o | output | 1 | High during any settling wait |
| phase_o | output | 3 | Current phase: 0 OFF, 1 ENABLED, 2 ON, 3 UP_WAIT, 4 DROP_WAIT, 5 SHUT_WAIT |

## Verification
The bench measures the settling window edge by edge, sampling both the last waiting cycle and the first cycle after it. A counter that is off by one therefore shows up as power arriving a cycle early or late. It drives a shutdown from the enabled-only phase, where a design that skips the wait would drop enable immediately. It also drives a down-to-enabled request, which a careless design would treat as a full shutdown. Two commands are sent into a running wait: a design that applies commands at once would change the outputs mid-wait, and one that keeps the oldest command would settle in the wrong phase. Redundant commands and a power-without-enable command test that nothing spurious starts and that power never appears without enable.

// File: rtl/lcd_pseq_pkg.sv
package lcd_pseq_pkg;

    typedef enum logic [2:0] {
        PH_OFF       = 3'd0,
        PH_ENABLED   = 3'd1,
        PH_ON        = 3'd2,
        PH_UP_WAIT   = 3'd3,
        PH_DROP_WAIT = 3'd4,
        PH_SHUT_WAIT = 3'd5
    } phase_e;

    typedef struct packed {
        logic want_en;
        logic want_pwr;
    } cmd_t;

    typedef struct packed {
        phase_e phase;
        logic   en;
        logic   pwr;
        logic   busy;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{phase: PH_OFF, en: 1'b0, pwr: 1'b0, busy: 1'b0};

endpackage

// File: rtl/lcd_pseq_timer.sv
module lcd_pseq_timer #(
    parameter int unsigned SETTLE_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES + 1) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lcd_pseq_hold.sv
module lcd_pseq_hold
    import lcd_pseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic capture_i,
    input  cmd_t cmd_i,
    input  logic consume_i,
    output logic valid_o,
    output cmd_t cmd_o
);
    typedef struct packed {
        logic valid;
        cmd_t cmd;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (consume_i) slot_d.valid = 1'b0;
        if (capture_i) begin
            slot_d.valid = 1'b1;
            slot_d.cmd   = cmd_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_o = slot_q.valid;
    assign cmd_o   = slot_q.cmd;

endmodule

// File: rtl/lcd_power_seq.sv
module lcd_power_seq
    import lcd_pseq_pkg::*;
#(
    // 20 ms at a 250 MHz reference clock
    parameter int unsigned SETTLE_CYCLES = 5_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid_i,
    input  logic       req_enable_i,
    input  logic       req_power_i,
    output logic       panel_en_o,
    output logic       panel_pwr_o,
    output logic       busy_o,
    output logic [2:0] phase_o
);
    seq_state_t s_d, s_q;
    cmd_t       req_cmd, held_cmd, take_cmd;
    logic       held_valid, take_valid, stable;
    logic       timer_start, timer_expired;

    assign req_cmd = '{want_en: req_enable_i, want_pwr: req_power_i};

    // Stable phases accept work; waits park it in the hold slot.
    assign stable     = !s_q.busy;
    assign take_valid = stable && (req_valid_i || held_valid);
    assign take_cmd   = req_valid_i ? req_cmd : held_cmd;

    lcd_pseq_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (req_valid_i && s_q.busy),
        .cmd_i     (req_cmd),
        .consume_i (stable && held_valid),
        .valid_o   (held_valid),
        .cmd_o     (held_cmd)
    );

    lcd_pseq_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (timer_start),
        .expired_o (timer_expired)
    );

    always_comb begin
        s_d         = s_q;
        timer_start = 1'b0;
        unique case (s_q.phase)
            PH_OFF, PH_ENABLED, PH_ON: begin
                if (take_valid) begin
                    if (!take_cmd.want_en) begin
                        // Shutdown: power off first (if on), then wait.
                        if (s_q.en) begin
                            s_d.pwr     = 1'b0;
                            s_d.phase   = PH_SHUT_WAIT;
                            s_d.busy    = 1'b1;
                            timer_start = 1'b1;
                        end
                    end else if (take_cmd.want_pwr) begin
                        if (!s_q.pwr) begin
                            s_d.en      = 1'b1;
                            s_d.phase   = PH_UP_WAIT;
                            s_d.busy    = 1'b1;
                            timer_start = 1'b1;
                        end
                    end else if (s_q.pwr) begin
                        s_d.pwr     = 1'b0;
                        s_d.phase   = PH_DROP_WAIT;
                        s_d.busy    = 1'b1;
                        timer_start = 1'b1;
                    end else begin
                        s_d.en    = 1'b1;
                        s_d.phase = PH_ENABLED;
                    end
                end
            end
            PH_UP_WAIT: begin
                if (timer_expired) begin
                    s_d.pwr   = 1'b1;
                    s_d.phase = PH_ON;
                    s_d.busy  = 1'b0;
                end
            end
            PH_DROP_WAIT: begin
                if (timer_expired) begin
                    s_d.phase = PH_ENABLED;
                    s_d.busy  = 1'b0;
                end
            end
            PH_SHUT_WAIT: begin
                if (timer_expired) begin
                    s_d.en    = 1'b0;
                    s_d.phase = PH_OFF;
                    s_d.busy  = 1'b0;
                end
            end
            default: s_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= SEQ_RESET;
        else        s_q <= s_d;
    end

    assign panel_en_o  = s_q.en;
    assign panel_pwr_o = s_q.pwr;
    assign busy_o      = s_q.busy;
    assign phase_o     = s_q.phase;

endmodule

// File: rtl/lcd_pseq_checker.sv
module lcd_pseq_checker #(
    parameter int unsigned SETTLE_CYCLES = 5_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       panel_en_o,
    input logic       panel_pwr_o,
    input logic       busy_o,
    input logic [2:0] phase_o
);
    localparam int RW = $clog2(SETTLE_CYCLES + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (!busy_o) run_q <= '0;
        else             run_q <= run_q + 1'b1;
    end

    a_r9_pwr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        panel_pwr_o |-> panel_en_o);

    a_r2_en_before_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_en_o) |-> !panel_pwr_o);

    a_r3_pwr_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_pwr_o) |-> ($past(phase_o) == 3'd3));

    a_r4_en_after_shut_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_en_o) |-> (!$past(panel_pwr_o) && $past(phase_o) == 3'd5));

    a_r10_busy_phase: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (phase_o >= 3'd3));

    a_r3_window_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && $past(busy_o)) |-> (run_q == RW'(SETTLE_CYCLES)));

endmodule

bind lcd_power_seq lcd_pseq_checker #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_pseq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .panel_en_o  (panel_en_o),
    .panel_pwr_o (panel_pwr_o),
    .busy_o      (busy_o),
    .phase_o     (phase_o)
);

// File: tb/test_lcd_power_seq.sv
`timescale 1ns/1ps
module test_lcd_power_seq;
    localparam int S = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_en = 1'b0, req_pwr = 1'b0;
    logic       o_en, o_pwr, o_busy;
    logic [2:0] o_ph;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    typedef struct {
        int    at;
        bit    en;
        bit    pwr;
        bit    busy;
        int    ph;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lcd_power_seq #(.SETTLE_CYCLES(S)) i_lcd_power_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_enable_i (req_en),
        .req_power_i  (req_pwr),
        .panel_en_o   (o_en),
        .panel_pwr_o  (o_pwr),
        .busy_o       (o_busy),
        .phase_o      (o_ph)
    );

    task automatic push(input int at, input bit en, input bit pwr, input bit busy,
                        input int ph, input string tag);
        exp_t e;
        e.at = at; e.en = en; e.pwr = pwr; e.busy = busy; e.ph = ph; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic send(input bit en, input bit pwr, output int t);
        @(negedge clk);
        req_valid = 1'b1; req_en = en; req_pwr = pwr;
        t = cyc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expectations as their cycle comes up.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (e.at != cyc) begin
                errors++;
                $display("FAIL %s: check for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
            end else if (o_en !== e.en || o_pwr !== e.pwr || o_busy !== e.busy || int'(o_ph) != e.ph) begin
                errors++;
                $display("FAIL %s: cyc %0d got en=%0b pwr=%0b busy=%0b phase=%0d expected en=%0b pwr=%0b busy=%0b phase=%0d",
                         e.tag, cyc, o_en, o_pwr, o_busy, o_ph, e.en, e.pwr, e.busy, e.ph);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t, t0, t1, t2;
        idle(5);
        rst_n = 1'b1;
        push(cyc + 1, 0, 0, 0, 0, "R1");
        idle(3);

        // R2/R3: power-up from off
        send(1, 1, t);
        push(t + 1, 1, 0, 1, 3, "R2");
        push(t + S, 1, 0, 1, 3, "R3");
        push(t + S + 1, 1, 1, 0, 2, "R3");
        idle(S + 3);

        // R11: repeat of current state
        send(1, 1, t);
        push(t + 1, 1, 1, 0, 2, "R11");
        push(t + 2, 1, 1, 0, 2, "R11");
        idle(3);

        // R7: drop to enabled only
        send(1, 0, t);
        push(t + 1, 1, 0, 1, 4, "R7");
        push(t + S, 1, 0, 1, 4, "R7");
        push(t + S + 1, 1, 0, 0, 1, "R7");
        idle(S + 3);

        // R5: shutdown with power already off
        send(0, 0, t);
        push(t + 1, 1, 0, 1, 5, "R5");
        push(t + S, 1, 0, 1, 5, "R5");
        push(t + S + 1, 0, 0, 0, 0, "R5");
        idle(S + 3);

        // R11: shutdown while off
        send(0, 0, t);
        push(t + 1, 0, 0, 0, 0, "R11");
        push(t + 3, 0, 0, 0, 0, "R11");
        idle(4);

        // R6: enable only from off
        send(1, 0, t);
        push(t + 1, 1, 0, 0, 1, "R6");
        idle(2);
        send(0, 0, t);
        push(t + S + 1, 0, 0, 0, 0, "R5");
        idle(S + 3);

        // R8: commands during a wait are held, newest wins
        send(1, 1, t0);
        send(1, 0, t1);
        send(0, 0, t2);
        push(t0 + 6, 1, 0, 1, 3, "R8");
        push(t0 + S, 1, 0, 1, 3, "R8");
        push(t0 + S + 1, 1, 1, 0, 2, "R8");
        push(t0 + S + 2, 1, 0, 1, 5, "R8");
        push(t0 + 2 * S + 1, 1, 0, 1, 5, "R8");
        push(t0 + 2 * S + 2, 0, 0, 0, 0, "R8");
        idle(2 * S + 4);

        // R4/R12: power on, then enable=0 with power=1 shuts down
        send(1, 1, t);
        push(t + S + 1, 1, 1, 0, 2, "R3");
        idle(S + 3);
        send(0, 1, t);
        push(t + 1, 1, 0, 1, 5, "R4");
        push(t + S, 1, 0, 1, 5, "R12");
        push(t + S + 1, 0, 0, 0, 0, "R4");
        idle(S + 3);

        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule